// File: doc/BRIEF.md
# Multicycle Issue Hazard Interlock

This block sits at the issue stage of an in-order pipeline. The execute stage behind it holds four functional units:

| Unit | Execute cycles | Latency | Initiation interval |
|---|---|---|---|
| integer ALU | 1 | 0 | 1 |
| pipelined FP adder | 4 | 3 | 1 |
| pipelined multiplier | 7 | 6 | 1 |
| non-pipelined divider | 25 | 24 | 25 |

Latency counts the cycles a consumer must wait beyond the next cycle. The initiation interval is the spacing required between two instructions of the same unit.

Each cycle the block looks at the candidate instruction and its current tracking state, and decides whether the instruction may leave issue. The candidate is described by a unit class, a destination register, two source registers and a use flag for each field.

It holds the instruction back in four cases:
- its unit is still inside its initiation interval;
- one of its sources waits on an unfinished result;
- its destination already has a write that would not land before its own;
- its writeback cycle is already taken on the single register write port.

The decision is combinational from registered state. An issued instruction updates the state at the clock edge. A stalled one leaves the state untouched.

The tracking state has three parts:
- a remaining-cycles counter per architectural register;
- a shifting one-hot reservation vector, one bit per future writeback cycle;
- a busy timer for every unit whose interval exceeds one.

Top module: `ilk_issue_interlock`

## Requirements
- R1: `issue` is high exactly when `in_valid` is high and no hazard is present. `stall` is high exactly when `in_valid` is high and a hazard is present. The two are never high together, and both are low when `in_valid` is low.
- R2: Class code 0 (ALU, latency 0) results can be consumed by an instruction in the very next cycle without a stall.
- R3: After a class code 1 (FP add, latency 3) writer issues in cycle t, a consumer naming its destination through either source field is stalled in cycles t+1 to t+3 and issues in t+4.
- R4: After a class code 2 (multiply, latency 6) writer issues in cycle t, a consumer of its destination issues no earlier than t+7.
- R5: After a class code 3 (divide, interval 25) instruction issues in cycle t, another divide stalls until cycle t+25 and issues then.
- R6: Instructions of classes 0, 1 and 2 may issue in consecutive cycles when no other hazard applies.
- R7: A writing instruction whose writeback cycle (issue cycle plus latency) equals that of a pending write is stalled.
- R8: A writing instruction whose destination has a pending write landing in the same or a later cycle than its own would is stalled until its own write would land strictly later.
- R9: A stalled instruction records nothing: if it is withdrawn, a later reader of its destination is not stalled on its account.
- R10: With `in_rd_a` or `in_rd_b` low the matching source field is ignored. With `in_wr` low the destination is ignored for dependence, ordering and write-port checks, and no write slot is reserved.
- R11: Reset clears all pending results, reservations and unit timers, so any instruction issues at once afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Candidate instruction present |
| in_cls | input | 2 | Unit class: 0 ALU, 1 FP add, 2 multiply, 3 divide |
| in_dst | input | log2(NUM_REGS) | Destination register |
| in_src_a | input | log2(NUM_REGS) | First source register |
| in_src_b | input | log2(NUM_REGS) | Second source register |
| in_rd_a | input | 1 | First source is used |
| in_rd_b | input | 1 | Second source is used |
| in_wr | input | 1 | Instruction writes its destination |
| issue | output | 1 | Instruction leaves issue this cycle |
| stall | output | 1 | Instruction is held this cycle |

## Verification
A bound checker keeps its own cycle-stamped model of readiness, last write cycle, divide spacing and write-port occupancy. With it, every cycle it confirms that no issued instruction breaks a dependence, reorders writes to one register, overlaps a divide interval or doubles up a write cycle, and that issue and stall split the valid flag cleanly. These properties only show that nothing unsafe issues. The bench scenarios are needed to show that the block does not stall longer than required: exact release cycles, back-to-back issue on pipelined units, withdrawal of a stalled instruction, ignored operand fields, and recovery from reset mid-flight.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    typedef enum logic [1:0] {
        UC_ALU  = 2'd0,
        UC_FADD = 2'd1,
        UC_MUL  = 2'd2,
        UC_DIV  = 2'd3
    } unit_cls_e;

    localparam int unsigned N_CLS = 4;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/ilk_reg_track.sv
module ilk_reg_track #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned CNT_W    = 5,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_a_en,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic             rd_b_en,
    input  logic [IDX_W-1:0] rd_b_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] new_lat,
    input  logic             commit,
    output logic             raw_hit,
    output logic             waw_hit
);
    typedef struct packed {
        logic [NUM_REGS-1:0][CNT_W-1:0] cnt;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (st_q.cnt[r] != '0) begin
                st_d.cnt[r] = st_q.cnt[r] - 1'b1;
            end
            if (commit && wr_en && (wr_idx == IDX_W'(r))) begin
                st_d.cnt[r] = new_lat;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic raw_a, raw_b;
    assign raw_a   = rd_a_en && (st_q.cnt[rd_a_idx] != '0);
    assign raw_b   = rd_b_en && (st_q.cnt[rd_b_idx] != '0);
    assign raw_hit = raw_a || raw_b;
    assign waw_hit = wr_en && (st_q.cnt[wr_idx] > new_lat);
endmodule

// File: rtl/ilk_wb_slots.sv
module ilk_wb_slots #(
    parameter int unsigned SLOT_N = 25,
    parameter int unsigned LAT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LAT_W-1:0] slot_idx,
    input  logic             commit,
    output logic             port_hit
);
    typedef struct packed {
        logic [SLOT_N-1:0] res;
    } slots_t;

    localparam logic [SLOT_N-1:0] ONE = SLOT_N'(1);

    slots_t            st_d, st_q;
    logic [SLOT_N-1:0] claimed;

    always_comb begin
        claimed = st_q.res;
        if (commit && wr_en) begin
            claimed = st_q.res | (ONE << slot_idx);
        end
        st_d.res = claimed >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_hit = wr_en && st_q.res[slot_idx];
endmodule

// File: rtl/ilk_unit_gate.sv
module ilk_unit_gate #(
    parameter int unsigned N_CLS          = 4,
    parameter int unsigned BUSY_W         = 5,
    parameter int unsigned II_TAB [N_CLS] = '{1, 1, 1, 25}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CLS-1:0] cls_oh,
    input  logic             commit,
    output logic             struct_hit
);
    logic [N_CLS-1:0] busy;

    for (genvar g = 0; g < N_CLS; g++) begin : g_cls
        if (II_TAB[g] > 1) begin : g_timer
            logic [BUSY_W-1:0] left_d, left_q;

            always_comb begin
                left_d = left_q;
                if (left_q != '0) begin
                    left_d = left_q - 1'b1;
                end
                if (commit && cls_oh[g]) begin
                    left_d = BUSY_W'(II_TAB[g] - 1);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    left_q <= '0;
                end else begin
                    left_q <= left_d;
                end
            end

            assign busy[g] = (left_q != '0);
        end else begin : g_free
            assign busy[g] = 1'b0;
        end
    end

    assign struct_hit = |(busy & cls_oh);
endmodule

// File: rtl/ilk_issue_interlock.sv
module ilk_issue_interlock #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned LAT_ALU  = 0,
    parameter int unsigned LAT_FADD = 3,
    parameter int unsigned LAT_MUL  = 6,
    parameter int unsigned LAT_DIV  = 24,
    parameter int unsigned II_ALU   = 1,
    parameter int unsigned II_FADD  = 1,
    parameter int unsigned II_MUL   = 1,
    parameter int unsigned II_DIV   = 25
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [1:0]                  in_cls,
    input  logic [$clog2(NUM_REGS)-1:0] in_dst,
    input  logic [$clog2(NUM_REGS)-1:0] in_src_a,
    input  logic [$clog2(NUM_REGS)-1:0] in_src_b,
    input  logic                        in_rd_a,
    input  logic                        in_rd_b,
    input  logic                        in_wr,
    output logic                        issue,
    output logic                        stall
);
    import ilk_pkg::*;

    localparam int unsigned LAT_TAB [N_CLS] = '{LAT_ALU, LAT_FADD, LAT_MUL, LAT_DIV};
    localparam int unsigned II_TAB  [N_CLS] = '{II_ALU, II_FADD, II_MUL, II_DIV};
    localparam int unsigned MAX_LAT = max_of4(LAT_ALU, LAT_FADD, LAT_MUL, LAT_DIV);
    localparam int unsigned MAX_II  = max_of4(II_ALU, II_FADD, II_MUL, II_DIV);
    localparam int unsigned SLOT_N  = MAX_LAT + 1;
    localparam int unsigned LAT_W   = (SLOT_N < 2) ? 1 : $clog2(SLOT_N);
    localparam int unsigned BUSY_W  = (MAX_II < 2) ? 1 : $clog2(MAX_II);

    logic [LAT_W-1:0] lat_sel;
    logic [N_CLS-1:0] cls_oh;
    logic             raw_hit, waw_hit, port_hit, struct_hit;
    logic             hazard;

    always_comb begin
        lat_sel = LAT_W'(LAT_TAB[in_cls]);
        cls_oh  = N_CLS'(1) << in_cls;
    end

    ilk_reg_track #(
        .NUM_REGS (NUM_REGS),
        .CNT_W    (LAT_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_en  (in_rd_a),
        .rd_a_idx (in_src_a),
        .rd_b_en  (in_rd_b),
        .rd_b_idx (in_src_b),
        .wr_en    (in_wr),
        .wr_idx   (in_dst),
        .new_lat  (lat_sel),
        .commit   (issue),
        .raw_hit  (raw_hit),
        .waw_hit  (waw_hit)
    );

    ilk_wb_slots #(
        .SLOT_N   (SLOT_N),
        .LAT_W    (LAT_W)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_wr),
        .slot_idx (lat_sel),
        .commit   (issue),
        .port_hit (port_hit)
    );

    ilk_unit_gate #(
        .N_CLS      (N_CLS),
        .BUSY_W     (BUSY_W),
        .II_TAB     (II_TAB)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cls_oh     (cls_oh),
        .commit     (issue),
        .struct_hit (struct_hit)
    );

    assign hazard = raw_hit || waw_hit || port_hit || struct_hit;
    assign stall  = in_valid && hazard;
    assign issue  = in_valid && !hazard;
endmodule

// File: rtl/ilk_issue_checker.sv
module ilk_issue_checker #(
    parameter int unsigned NUM_REGS       = 32,
    parameter int unsigned LAT_TAB [4]    = '{0, 3, 6, 24},
    parameter int unsigned II_DIV         = 25
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [1:0]                  in_cls,
    input logic [$clog2(NUM_REGS)-1:0] in_dst,
    input logic [$clog2(NUM_REGS)-1:0] in_src_a,
    input logic [$clog2(NUM_REGS)-1:0] in_src_b,
    input logic                        in_rd_a,
    input logic                        in_rd_b,
    input logic                        in_wr,
    input logic                        issue,
    input logic                        stall
);
    int unsigned now;
    int unsigned lat;
    int unsigned div_gap;
    int unsigned ready_at [NUM_REGS];
    int unsigned wb_at    [NUM_REGS];
    logic [63:0] ring;

    always_comb lat = LAT_TAB[in_cls];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now     <= 1;
            div_gap <= II_DIV;
            ring    <= '0;
            for (int r = 0; r < NUM_REGS; r++) begin
                ready_at[r] <= 0;
                wb_at[r]    <= 0;
            end
        end else begin
            now <= now + 1;
            ring[6'(now)] <= 1'b0;
            if (issue && in_wr) begin
                if (lat != 0) ring[6'(now + lat)] <= 1'b1;
                ready_at[in_dst] <= now + lat + 1;
                wb_at[in_dst]    <= now + lat;
            end
            if (issue && (in_cls == 2'd3)) begin
                div_gap <= 1;
            end else if (div_gap < II_DIV) begin
                div_gap <= div_gap + 1;
            end
        end
    end

    // R1
    p_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (issue != stall));
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue && !stall));
    // R3 (also covers R2 and R4): no read before the producer's result is ready
    p_raw_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_rd_a) |-> (now >= ready_at[in_src_a]));
    p_raw_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_rd_b) |-> (now >= ready_at[in_src_b]));
    p_div_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (in_cls == 2'd3)) |-> (div_gap >= II_DIV));
    p_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_wr) |-> !ring[6'(now + lat)]);
    p_waw_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_wr) |-> ((now + lat) > wb_at[in_dst]));
endmodule

bind ilk_issue_interlock ilk_issue_checker #(
    .NUM_REGS (NUM_REGS),
    .LAT_TAB  ('{LAT_ALU, LAT_FADD, LAT_MUL, LAT_DIV}),
    .II_DIV   (II_DIV)
) u_chk (.*);

// File: tb/tb_ilk_issue_interlock.sv
module tb_ilk_issue_interlock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_cls = 2'd0;
    logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic       in_rd_a = 1'b0, in_rd_b = 1'b0, in_wr = 1'b0;
    logic       issue, stall;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    ilk_issue_interlock dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_rd_a(in_rd_a), .in_rd_b(in_rd_b), .in_wr(in_wr),
        .issue(issue), .stall(stall)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] c;
        logic [4:0] d;
        logic [4:0] a;
        logic [4:0] b;
        logic       ra;
        logic       rb;
        logic       wr;
        logic       ex;
    } vec_t;

    // one entry per cycle: valid, class, dst, srcA, srcB, useA, useB, write, expected issue
    localparam int N_VEC = 35;
    localparam vec_t TBL [N_VEC] = '{
        '{1'b1, 2'd0, 5'd1,  5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 0  R2 producer
        '{1'b1, 2'd0, 5'd2,  5'd1,  5'd0,  1'b1, 1'b0, 1'b1, 1'b1}, // 1  R2 consumer
        '{1'b1, 2'd1, 5'd3,  5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 2  R3 producer
        '{1'b1, 2'd0, 5'd4,  5'd0,  5'd3,  1'b0, 1'b1, 1'b1, 1'b0}, // 3  R3
        '{1'b1, 2'd0, 5'd4,  5'd0,  5'd3,  1'b0, 1'b1, 1'b1, 1'b0}, // 4  R3
        '{1'b1, 2'd0, 5'd4,  5'd0,  5'd3,  1'b0, 1'b1, 1'b1, 1'b0}, // 5  R3
        '{1'b1, 2'd0, 5'd4,  5'd0,  5'd3,  1'b0, 1'b1, 1'b1, 1'b1}, // 6  R3 release
        '{1'b1, 2'd1, 5'd6,  5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 7  R6
        '{1'b1, 2'd1, 5'd7,  5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 8  R6
        '{1'b1, 2'd2, 5'd8,  5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 9  R6 / R4 producer
        '{1'b1, 2'd1, 5'd9,  5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 10 R6
        '{1'b1, 2'd0, 5'd10, 5'd8,  5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 11 R4
        '{1'b1, 2'd0, 5'd10, 5'd8,  5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 12 R4
        '{1'b1, 2'd0, 5'd10, 5'd8,  5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 13 R4
        '{1'b1, 2'd0, 5'd10, 5'd8,  5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 14 R4
        '{1'b1, 2'd0, 5'd10, 5'd8,  5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 15 R4
        '{1'b1, 2'd0, 5'd10, 5'd8,  5'd0,  1'b1, 1'b0, 1'b1, 1'b1}, // 16 R4 release
        '{1'b1, 2'd1, 5'd11, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 17 R7 writes in 20
        '{1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // 18 R1 idle
        '{1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // 19 R1 idle
        '{1'b1, 2'd0, 5'd12, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0}, // 20 R7 same write cycle
        '{1'b1, 2'd0, 5'd12, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 21 R7 release
        '{1'b1, 2'd2, 5'd13, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 22 R8 mul writes in 28
        '{1'b1, 2'd1, 5'd13, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0}, // 23 R8
        '{1'b1, 2'd1, 5'd13, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0}, // 24 R8
        '{1'b1, 2'd1, 5'd13, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0}, // 25 R8
        '{1'b1, 2'd1, 5'd13, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 26 R8 release, writes in 29
        '{1'b1, 2'd0, 5'd14, 5'd13, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 27 R3 on latest writer
        '{1'b1, 2'd0, 5'd14, 5'd13, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 28 R3
        '{1'b1, 2'd0, 5'd14, 5'd13, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0}, // 29 R3
        '{1'b1, 2'd0, 5'd14, 5'd13, 5'd0,  1'b1, 1'b0, 1'b1, 1'b1}, // 30 R3 release
        '{1'b1, 2'd2, 5'd15, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // 31 R10 mul writes in 37
        '{1'b1, 2'd0, 5'd16, 5'd15, 5'd15, 1'b0, 1'b0, 1'b1, 1'b1}, // 32 R10 unused sources
        '{1'b1, 2'd0, 5'd15, 5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b1}, // 33 R10 no write, no WAW
        '{1'b1, 2'd1, 5'd17, 5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b1}  // 34 R10 no write, no port
    };

    task automatic chk(input string tag, input logic act_i, input logic act_s,
                       input logic exp_i, input logic exp_s);
        n_chk++;
        if (act_i !== exp_i || act_s !== exp_s) begin
            n_fail++;
            $display("FAIL %s: issue=%0b stall=%0b expected issue=%0b stall=%0b",
                     tag, act_i, act_s, exp_i, exp_s);
        end
    endtask

    task automatic put(input logic v, input logic [1:0] c, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b,
                       input logic ra, input logic rb, input logic wr);
        in_valid = v; in_cls = c; in_dst = d; in_src_a = a; in_src_b = b;
        in_rd_a = ra; in_rd_b = rb; in_wr = wr;
    endtask

    task automatic step(input string tag, input logic v, input logic [1:0] c,
                        input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                        input logic ra, input logic rb, input logic wr, input logic ex);
        @(negedge clk);
        put(v, c, d, a, b, ra, rb, wr);
        #2;
        chk(tag, issue, stall, ex, v && !ex);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            put(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R11 reset state: idle inputs give no issue and no stall
        repeat (2) @(negedge clk);
        #2;
        chk("R11 reset idle", issue, stall, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // table of per-cycle vectors (R1..R4, R6..R8, R10)
        for (int i = 0; i < N_VEC; i++) begin
            @(negedge clk);
            put(TBL[i].v, TBL[i].c, TBL[i].d, TBL[i].a, TBL[i].b,
                TBL[i].ra, TBL[i].rb, TBL[i].wr);
            #2;
            chk($sformatf("R1 table entry %0d", i), issue, stall,
                TBL[i].ex, TBL[i].v && !TBL[i].ex);
        end
        idle(10);

        // R5: second divide held for the whole interval
        step("R5 first divide", 1'b1, 2'd3, 5'd20, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int k = 1; k <= 25; k++) begin
            step($sformatf("R5 second divide at +%0d", k), 1'b1, 2'd3, 5'd21,
                 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, (k == 25));
        end
        idle(30);

        // R9: withdrawn stalled divide leaves no pending result
        step("R9 divide", 1'b1, 2'd3, 5'd22, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R9 held divide", 1'b1, 2'd3, 5'd23, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R9 withdrawn", 1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R9 reader of withdrawn dst", 1'b1, 2'd0, 5'd24, 5'd23, 5'd0,
             1'b1, 1'b0, 1'b1, 1'b1);

        // R11: reset in flight clears pending multiply and divider timer
        step("R11 multiply", 1'b1, 2'd2, 5'd1, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        put(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step("R11 reader after reset", 1'b1, 2'd0, 5'd2, 5'd1, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R11 divide after reset", 1'b1, 2'd3, 5'd25, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(2);
        finish_run();
    end
endmodule